// File: doc/BRIEF.md
# I2C Register-Access Sequencer

This block is a single-controller I2C master that carries out a complete register transaction each time it is started. The host places a 7-bit target address, an 8-bit register index, a byte count and a direction on the inputs, then pulses `start_i`. For a write, the block sends START, the address with the write bit, the index, and then the data bytes, which it takes one at a time from `wr_data_i`. It ends with STOP. For a read, it sends START, the address with the write bit and the index. It then turns the bus round with a repeated START, sends the address with the read bit, and collects the requested number of bytes. It acknowledges every byte except the last one, which gets a NACK before the STOP.

SCL is produced from a programmable divider. Each bit symbol is split into four quarters of `div_i + 1` clock cycles. SDA is moved only in the quarters where SCL is low, except for the deliberate START and STOP edges. Each received byte is presented on `rd_data_o` with a one-cycle `rd_valid_o`. A NACK on any byte the controller sends ends the transaction with STOP and raises `err_o` together with `done_o`.

Top module: `i2c_regseq`

## Requirements
- R1: After reset and whenever no transaction is running, `scl_o` and `sda_o` are both 1 (released), and `busy_o` and `done_o` are 0.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A write transaction shows exactly one START and one STOP on the bus. A read transaction shows two STARTs (the second one repeated) and one STOP.
- R3: Apart from the START, repeated-START and STOP edges, SDA changes only while SCL is low.
- R4: Each address byte goes out MSB first as the 7-bit address followed by a direction bit in bit 0 of the byte on the wire (0 = write, 1 = read). On the 9th clock SDA is released so the target can acknowledge. A read sends `{addr,0}` and then `{addr,1}`.
- R5: A write sends the index and then N data bytes, each followed by a target ACK, then STOP. `wr_take_o` pulses once for each byte taken from `wr_data_i`. A byte count of 0 is handled as 1.
- R6: During a read the controller drives ACK (SDA low) in the 9th slot after every byte except the last. It drives NACK (SDA high) after the last byte, then STOP.
- R7: Each received byte is assembled MSB first and shown on `rd_data_o` with a one-cycle `rd_valid_o`. There are exactly N pulses per successful read, and none during writes.
- R8: A NACK on an address, index or write-data byte is followed directly by STOP, and `done_o` then comes with `err_o` = 1. No further byte is taken. `err_o` stays valid until the next accepted start, and it is 0 after a fully acknowledged transaction.
- R9: Within a byte, SCL stays high for 2·(div_i+1) cycles. The spacing between successive SCL rising edges is 4·(div_i+1)+2 cycles, of which 2 cycles are symbol hand-off.
- R10: `start_i` has no effect while `busy_o` is 1.
- R11: `done_o` is a single-cycle pulse at the end of STOP, and `busy_o` is already 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_i | input | DIV_W | Quarter-period length minus one, in clock cycles |
| start_i | input | 1 | Begin a transaction (ignored while busy) |
| rd_mode_i | input | 1 | 1 = register read, 0 = register write |
| tgt_addr_i | input | 7 | Target address |
| reg_idx_i | input | 8 | Register index sent after the address |
| byte_cnt_i | input | CNT_W | Number of data bytes (0 treated as 1) |
| wr_data_i | input | 8 | Next write byte, taken on `wr_take_o` |
| wr_take_o | output | 1 | Pulse: a write byte was loaded |
| rd_data_o | output | 8 | Last received byte |
| rd_valid_o | output | 1 | Pulse: `rd_data_o` holds a new byte |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | Pulse: transaction finished |
| err_o | output | 1 | Last transaction ended on a NACK |
| scl_o | output | 1 | SCL drive (1 = release) |
| sda_o | output | 1 | SDA drive (1 = release) |
| sda_i | input | 1 | Sensed SDA line |

## Verification
The scoreboard drives several kinds of transaction against a behavioural target that holds a register array:
- A multi-byte write, followed by a multi-byte read over the same locations. This separates the index phase and the auto-increment from the byte ordering.
- A read at the fastest divider. This shows whether sampling holds when quarters are one cycle long.
- A wrong target address and a NACK injected mid-write. These separate address-phase failures from data-phase failures through the take count and the untouched register contents.
- A zero byte count, a start pulse during a busy write, and a timed read at a slower divider. These cover the count rule, the start-ignore rule and the SCL timing.

// File: rtl/i2c_regseq_pkg.sv
package i2c_regseq_pkg;

  typedef enum logic [1:0] {
    SYM_START  = 2'd0,
    SYM_RSTART = 2'd1,
    SYM_STOP   = 2'd2,
    SYM_BIT    = 2'd3
  } sym_e;

  typedef enum logic [3:0] {
    T_IDLE, T_START, T_AW, T_IDX, T_WD, T_RS, T_AR, T_RD, T_STOP
  } tstate_e;

  // Line levels {scl, sda} for quarter q of a symbol.
  function automatic logic [1:0] quarter_lines(input sym_e s, input logic b,
                                               input logic [1:0] q);
    logic [1:0] r;
    unique case (s)
      SYM_START:  r = (q == 2'd3) ? 2'b00 : (q == 2'd2) ? 2'b10 : 2'b11;
      SYM_RSTART: r = (q == 2'd0) ? 2'b01 : (q == 2'd1) ? 2'b11 :
                      (q == 2'd2) ? 2'b10 : 2'b00;
      SYM_STOP:   r = (q == 2'd0) ? 2'b00 : (q == 2'd1) ? 2'b10 : 2'b11;
      default:    r = {(q == 2'd1 || q == 2'd2), b};
    endcase
    return r;
  endfunction

  // On-wire address byte: address in bits 7:1, direction in bit 0.
  function automatic logic [7:0] addr_byte(input logic [6:0] a, input logic rd);
    return {a, rd};
  endfunction

endpackage

// File: rtl/i2c_rs_tick.sv
module i2c_rs_tick #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt;

  assign tick_o = run_i && (cnt == div_i);

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) cnt <= '0;
    else if (cnt == div_i) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && div_i != '0 && run_i) |=> (!tick_o || div_i == '0)); // R9

endmodule

// File: rtl/i2c_rs_line.sv
module i2c_rs_line
  import i2c_regseq_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  input  logic             go_i,
  input  sym_e             sym_i,
  input  logic             bit_i,
  input  logic             sda_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             rbit_o,
  output logic             scl_o,
  output logic             sda_o
);
  logic       active;
  logic [1:0] q;
  sym_e       sym_q;
  logic       bit_q;
  logic       scl_q, sda_q, rbit_q, done_q;
  logic       tick;
  logic       accept_sym;
  logic       last_quarter;

  assign accept_sym   = go_i && !active;
  assign last_quarter = active && tick && (q == 2'd3);

  i2c_rs_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run_i(active), .div_i(div_i), .tick_o(tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      q      <= 2'd0;
      sym_q  <= SYM_BIT;
      bit_q  <= 1'b1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      rbit_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept_sym) begin
        active         <= 1'b1;
        q              <= 2'd0;
        sym_q          <= sym_i;
        bit_q          <= bit_i;
        {scl_q, sda_q} <= quarter_lines(sym_i, bit_i, 2'd0);
      end else if (last_quarter) begin
        active <= 1'b0;
        done_q <= 1'b1;
      end else if (active && tick) begin
        q              <= q + 2'd1;
        {scl_q, sda_q} <= quarter_lines(sym_q, bit_q, q + 2'd1);
        if (q == 2'd1) rbit_q <= sda_i;
      end
    end
  end

  assign busy_o = active;
  assign done_o = done_q;
  assign rbit_o = rbit_q;
  assign scl_o  = scl_q;
  assign sda_o  = sda_q;

  AST_SDA_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && sym_q == SYM_BIT && scl_q && $past(scl_q))
      |-> $stable(sda_q)); // R3

  AST_START_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && sym_q != SYM_STOP && $fell(sda_q))
      |-> (scl_q || sym_q == SYM_BIT)); // R2

  AST_STOP_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && sym_q == SYM_STOP && $rose(sda_q))
      |-> (scl_q && $past(scl_q))); // R2

endmodule

// File: rtl/i2c_regseq.sv
module i2c_regseq
  import i2c_regseq_pkg::*;
#(
  parameter int DIV_W = 12,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  input  logic             start_i,
  input  logic             rd_mode_i,
  input  logic [6:0]       tgt_addr_i,
  input  logic [7:0]       reg_idx_i,
  input  logic [CNT_W-1:0] byte_cnt_i,
  input  logic [7:0]       wr_data_i,
  output logic             wr_take_o,
  output logic [7:0]       rd_data_o,
  output logic             rd_valid_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic             scl_o,
  output logic             sda_o,
  input  logic             sda_i
);
  localparam logic [3:0] ACK_SLOT = 4'd8;
  localparam logic [3:0] LAST_BIT = 4'd7;

  tstate_e          st;
  logic [3:0]       bc;
  logic [7:0]       sh;
  logic [CNT_W-1:0] rem;
  logic             rd_q, err_q, done_q, take_q, rvalid_q;
  logic [6:0]       addr_q;
  logic [7:0]       idx_q, rdata_q;

  logic l_busy, l_done, l_rbit, l_go, l_bit;
  sym_e l_sym;

  // Named internal events.
  logic accept, ack_slot_end, got_nack, last_rd;

  function automatic logic [CNT_W-1:0] eff_count(input logic [CNT_W-1:0] c);
    return (c == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : c;
  endfunction

  function automatic sym_e sym_of(input tstate_e s);
    unique case (s)
      T_START: return SYM_START;
      T_RS:    return SYM_RSTART;
      T_STOP:  return SYM_STOP;
      default: return SYM_BIT;
    endcase
  endfunction

  function automatic logic drive_bit(input tstate_e s, input logic [3:0] n,
                                     input logic msb, input logic last);
    if (n == ACK_SLOT) return (s == T_RD) ? last : 1'b1;
    return (s == T_RD) ? 1'b1 : msb;
  endfunction

  assign accept       = start_i && (st == T_IDLE);
  assign ack_slot_end = l_done && (bc == ACK_SLOT);
  assign got_nack     = ack_slot_end && l_rbit && (st != T_RD);
  assign last_rd      = (rem == '0);

  assign l_go  = (st != T_IDLE) && !l_busy && !l_done;
  assign l_sym = sym_of(st);
  assign l_bit = drive_bit(st, bc, sh[7], last_rd);

  i2c_rs_line #(.DIV_W(DIV_W)) u_line (
    .clk(clk), .rst_n(rst_n), .div_i(div_i), .go_i(l_go), .sym_i(l_sym),
    .bit_i(l_bit), .sda_i(sda_i), .busy_o(l_busy), .done_o(l_done),
    .rbit_o(l_rbit), .scl_o(scl_o), .sda_o(sda_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= T_IDLE; bc <= '0; sh <= '0; rem <= '0; rd_q <= 1'b0;
      addr_q <= '0; idx_q <= '0; err_q <= 1'b0; done_q <= 1'b0;
      take_q <= 1'b0; rvalid_q <= 1'b0; rdata_q <= '0;
    end else begin
      done_q   <= 1'b0;
      take_q   <= 1'b0;
      rvalid_q <= 1'b0;
      if (accept) begin
        st     <= T_START;
        rd_q   <= rd_mode_i;
        addr_q <= tgt_addr_i;
        idx_q  <= reg_idx_i;
        rem    <= eff_count(byte_cnt_i);
        err_q  <= 1'b0;
        bc     <= '0;
      end else if (l_done) begin
        unique case (st)
          T_START: begin st <= T_AW; sh <= addr_byte(addr_q, 1'b0); bc <= '0; end
          T_RS:    begin st <= T_AR; sh <= addr_byte(addr_q, 1'b1); bc <= '0; end
          T_STOP:  begin st <= T_IDLE; done_q <= 1'b1; end
          T_RD: begin
            if (bc != ACK_SLOT) begin
              sh <= {sh[6:0], l_rbit};
              bc <= bc + 4'd1;
              if (bc == LAST_BIT) begin
                rdata_q  <= {sh[6:0], l_rbit};
                rvalid_q <= 1'b1;
                rem      <= rem - 1'b1;
              end
            end else begin
              bc <= '0;
              if (last_rd) st <= T_STOP;
            end
          end
          T_AW, T_IDX, T_WD, T_AR: begin
            if (bc != ACK_SLOT) begin
              sh <= {sh[6:0], 1'b0};
              bc <= bc + 4'd1;
            end else if (got_nack) begin
              err_q <= 1'b1;
              st    <= T_STOP;
            end else begin
              bc <= '0;
              if (st == T_AW) begin
                st <= T_IDX; sh <= idx_q;
              end else if (st == T_AR) begin
                st <= T_RD;
              end else if (st == T_IDX && rd_q) begin
                st <= T_RS;
              end else if (st == T_WD && last_rd) begin
                st <= T_STOP;
              end else begin
                st <= T_WD; sh <= wr_data_i; take_q <= 1'b1; rem <= rem - 1'b1;
              end
            end
          end
          default: st <= T_IDLE;
        endcase
      end
    end
  end

  assign wr_take_o  = take_q;
  assign rd_data_o  = rdata_q;
  assign rd_valid_o = rvalid_q;
  assign busy_o     = (st != T_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (scl_o && sda_o)); // R1

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R11

  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o) |=> ($stable(addr_q) && $stable(rd_q) && $stable(idx_q))); // R10

  AST_VALID_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> rd_q); // R7

  AST_TAKE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take_o |-> !rd_q); // R5

  AST_NACK_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> (st == T_STOP)); // R8

endmodule

// File: tb/sim_i2c_regseq.sv
`timescale 1ns/1ps
module sim_i2c_regseq;
  localparam int DIV_W = 12;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_n = 1'b0;
  logic [DIV_W-1:0] div = '0;
  logic             start = 1'b0, rd_mode = 1'b0;
  logic [6:0]       taddr = '0;
  logic [7:0]       ridx = '0;
  logic [CNT_W-1:0] bcnt = '0;
  logic [7:0]       wdata = '0;
  logic             wr_take, rd_valid, busy, done, err, scl, sda_m;
  logic [7:0]       rd_data;
  logic             tgt_sda = 1'b1;
  wire              bus_sda = sda_m & tgt_sda;

  i2c_regseq #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .div_i(div), .start_i(start), .rd_mode_i(rd_mode),
    .tgt_addr_i(taddr), .reg_idx_i(ridx), .byte_cnt_i(bcnt), .wr_data_i(wdata),
    .wr_take_o(wr_take), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .busy_o(busy), .done_o(done), .err_o(err), .scl_o(scl), .sda_o(sda_m),
    .sda_i(bus_sda)
  );

  int n_cmp = 0, n_bad = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) ^ 8'h5A);
  endfunction

  // ---------------- behavioural target ----------------
  logic [6:0] tgt_id = 7'h5A;
  int         nack_byte = -1;
  logic [7:0] mem [0:255];
  logic [7:0] exp_mem [0:255];
  logic [7:0] ptr = '0;
  int         bitn = -1, byten = 0;
  logic [7:0] sh_t = '0, tx = '0;
  logic       matched = 1'b0, rdir = 1'b0, last_ack = 1'b0, mack = 1'b1, txm = 1'b0;
  logic       ps = 1'b1, pd = 1'b1;
  int         n_start = 0, n_stop = 0;
  logic [7:0] addr_log [$];
  logic       mack_log [$];

  initial for (int i = 0; i < 256; i++) begin mem[i] = pat(i); exp_mem[i] = pat(i); end

  always @(negedge clk) begin
    logic sl, dl, ackv;
    sl = scl; dl = bus_sda;
    if (ps && sl && pd && !dl) begin
      n_start++; bitn = -1; byten = 0; txm = 1'b0; tgt_sda = 1'b1;
    end else if (ps && sl && !pd && dl) begin
      n_stop++; bitn = -1; txm = 1'b0; tgt_sda = 1'b1;
    end else if (!ps && sl) begin
      if (bitn >= 0 && bitn < 8 && !txm) sh_t = {sh_t[6:0], dl};
      if (bitn == 8 && txm) begin mack = dl; mack_log.push_back(dl); end
    end else if (ps && !sl) begin
      bitn++;
      if (bitn == 8) begin
        if (txm) tgt_sda = 1'b1;
        else begin
          ackv = 1'b1;
          if (byten == 0) begin
            addr_log.push_back(sh_t);
            matched = (sh_t[7:1] == tgt_id);
            rdir = sh_t[0];
          end
          if (byten == nack_byte || !matched) ackv = 1'b0;
          if (ackv && byten == 1) ptr = sh_t;
          else if (ackv && byten >= 2) begin mem[ptr] = sh_t; ptr++; end
          last_ack = ackv;
          tgt_sda = !ackv;
        end
      end else if (bitn == 9) begin
        bitn = 0; tgt_sda = 1'b1;
        if (txm && mack) txm = 1'b0;
        if (byten == 0 && rdir && last_ack) txm = 1'b1;
        byten++;
        if (txm) begin tx = mem[ptr]; ptr++; tgt_sda = tx[7]; end
      end else if (bitn >= 1 && bitn <= 7 && txm) begin
        tgt_sda = tx[7 - bitn];
      end
    end
    ps = sl; pd = dl;
  end

  // ---------------- write-data feeder ----------------
  logic [7:0] wbuf [0:7];
  int widx = 0, take_cnt = 0;
  always @(negedge clk) if (wr_take) begin
    take_cnt++; widx = (widx + 1) % 8; wdata = wbuf[widx];
  end

  // ---------------- read scoreboard ----------------
  logic [7:0] exp_q [$];
  int n_valid = 0;
  always @(negedge clk) if (rd_valid) begin
    n_valid++;
    if (exp_q.size() == 0) chk(1'b0, "R7", "unexpected rd_valid", int'(rd_data), -1);
    else begin
      logic [7:0] e;
      e = exp_q.pop_front();
      chk(rd_data == e, "R7", "read byte", int'(rd_data), int'(e));
    end
  end

  task automatic kick(input bit rd, input logic [6:0] a, input logic [7:0] ix,
                      input int cnt, input int dv);
    @(negedge clk);
    div = DIV_W'(dv); rd_mode = rd; taddr = a; ridx = ix; bcnt = CNT_W'(cnt);
    widx = 0; wdata = wbuf[0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_txn(output bit e);
    while (!done) @(negedge clk);
    e = err;
    chk(busy == 1'b0, "R11", "busy low with done", int'(busy), 0);
    @(negedge clk);
    chk(done == 1'b0, "R11", "done one cycle", int'(done), 0);
  endtask

  task automatic summary_and_end();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary_and_end();
  end

  initial begin
    bit e;
    int s0, p0, t0, m0, v0;
    realtime t1, t2, t3;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(scl == 1'b1 && sda_m == 1'b1, "R1", "lines released after reset", int'({scl, sda_m}), 3);
    chk(busy == 1'b0 && done == 1'b0, "R1", "busy/done after reset", int'({busy, done}), 0);

    // Write of three bytes at index 0x10.
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3; wbuf[3] = 8'hD4;
    s0 = n_start; p0 = n_stop; t0 = take_cnt;
    kick(1'b0, 7'h5A, 8'h10, 3, 3);
    finish_txn(e);
    for (int k = 0; k < 3; k++) exp_mem[8'h10 + k] = wbuf[k];
    chk(e == 1'b0, "R8", "err after acked write", int'(e), 0);
    chk(take_cnt - t0 == 3, "R5", "write takes", take_cnt - t0, 3);
    for (int k = 0; k < 3; k++)
      chk(mem[8'h10 + k] == exp_mem[8'h10 + k], "R5", "written register", int'(mem[8'h10 + k]), int'(exp_mem[8'h10 + k]));
    chk(mem[8'h13] == exp_mem[8'h13], "R5", "register past end untouched", int'(mem[8'h13]), int'(exp_mem[8'h13]));
    chk(n_start - s0 == 1 && n_stop - p0 == 1, "R2", "write START/STOP count", (n_start - s0) * 10 + (n_stop - p0), 11);
    chk(addr_log[$] == 8'hB4, "R4", "write address byte", int'(addr_log[$]), 'hB4);
    chk(scl == 1'b1 && sda_m == 1'b1, "R1", "lines released after write", int'({scl, sda_m}), 3);

    // Read of four bytes from 0x0F (spans the written registers).
    s0 = n_start; p0 = n_stop; t0 = take_cnt; m0 = mack_log.size(); v0 = n_valid;
    for (int k = 0; k < 4; k++) exp_q.push_back(exp_mem[8'h0F + k]);
    kick(1'b1, 7'h5A, 8'h0F, 4, 3);
    finish_txn(e);
    chk(e == 1'b0, "R8", "err after read", int'(e), 0);
    chk(n_valid - v0 == 4, "R7", "valid pulse count", n_valid - v0, 4);
    chk(take_cnt == t0, "R5", "no take during read", take_cnt - t0, 0);
    chk(n_start - s0 == 2 && n_stop - p0 == 1, "R2", "read START/STOP count", (n_start - s0) * 10 + (n_stop - p0), 21);
    chk(addr_log[$ - 1] == 8'hB4 && addr_log[$] == 8'hB5, "R4", "read address pair",
        int'({addr_log[$ - 1], addr_log[$]}), 'hB4B5);
    chk(mack_log.size() - m0 == 4, "R6", "controller ack slots", mack_log.size() - m0, 4);
    for (int k = 0; k < 4; k++)
      chk(mack_log[m0 + k] == (k == 3), "R6", "ack/nack level", int'(mack_log[m0 + k]), int'(k == 3));

    // Fast divider read of two bytes.
    v0 = n_valid;
    for (int k = 0; k < 2; k++) exp_q.push_back(exp_mem[8'h40 + k]);
    kick(1'b1, 7'h5A, 8'h40, 2, 0);
    finish_txn(e);
    chk(n_valid - v0 == 2 && e == 1'b0, "R7", "fast read count", n_valid - v0, 2);

    // Wrong address: NACK on address byte.
    t0 = take_cnt; p0 = n_stop;
    kick(1'b0, 7'h11, 8'h50, 2, 3);
    finish_txn(e);
    chk(e == 1'b1, "R8", "err on address nack", int'(e), 1);
    chk(take_cnt == t0, "R8", "no take after address nack", take_cnt - t0, 0);
    chk(n_stop - p0 == 1, "R8", "STOP after nack", n_stop - p0, 1);
    chk(addr_log[$] == 8'h22, "R4", "address byte of wrong target", int'(addr_log[$]), 'h22);
    repeat (20) @(negedge clk);
    chk(err == 1'b1, "R8", "err held", int'(err), 1);
    chk(scl == 1'b1 && sda_m == 1'b1 && !busy, "R1", "idle after nack", int'({busy, scl, sda_m}), 3);

    // NACK on the second data byte (frame byte 3).
    nack_byte = 3;
    wbuf[0] = 8'h3C; wbuf[1] = 8'h4D; wbuf[2] = 8'h5E; wbuf[3] = 8'h6F;
    t0 = take_cnt;
    kick(1'b0, 7'h5A, 8'h20, 4, 2);
    finish_txn(e);
    nack_byte = -1;
    exp_mem[8'h20] = 8'h3C;
    chk(e == 1'b1, "R8", "err on data nack", int'(e), 1);
    chk(take_cnt - t0 == 2, "R8", "takes before data nack", take_cnt - t0, 2);
    chk(mem[8'h20] == exp_mem[8'h20], "R8", "first byte stored", int'(mem[8'h20]), int'(exp_mem[8'h20]));
    chk(mem[8'h21] == exp_mem[8'h21], "R8", "nacked byte not stored", int'(mem[8'h21]), int'(exp_mem[8'h21]));

    // Zero count means one byte.
    wbuf[0] = 8'h99; wbuf[1] = 8'h77;
    t0 = take_cnt;
    kick(1'b0, 7'h5A, 8'h30, 0, 3);
    finish_txn(e);
    exp_mem[8'h30] = 8'h99;
    chk(e == 1'b0 && err == 1'b0, "R8", "err cleared by new start", int'(err), 0);
    chk(take_cnt - t0 == 1, "R5", "count zero takes one", take_cnt - t0, 1);
    chk(mem[8'h30] == exp_mem[8'h30] && mem[8'h31] == exp_mem[8'h31], "R5", "count zero register",
        int'(mem[8'h31]), int'(exp_mem[8'h31]));

    // SCL timing at div = 5, single-byte read.
    exp_q.push_back(exp_mem[8'h12]);
    m0 = mack_log.size();
    kick(1'b1, 7'h5A, 8'h12, 1, 5);
    @(posedge scl); t1 = $realtime;
    @(posedge scl); t2 = $realtime;
    @(negedge scl); t3 = $realtime;
    finish_txn(e);
    chk(int'((t2 - t1) / 5.0) == 26, "R9", "rise spacing", int'((t2 - t1) / 5.0), 26);
    chk(int'((t3 - t2) / 5.0) == 12, "R9", "high time", int'((t3 - t2) / 5.0), 12);
    chk(mack_log.size() - m0 == 1 && mack_log[$] == 1'b1, "R6", "single byte gets NACK", int'(mack_log[$]), 1);

    // Start pulse while busy is ignored.
    wbuf[0] = 8'h5C;
    s0 = n_start; v0 = n_valid;
    kick(1'b0, 7'h5A, 8'h60, 1, 3);
    repeat (60) @(negedge clk);
    rd_mode = 1'b1; ridx = 8'h77; start = 1'b1;
    @(negedge clk); start = 1'b0;
    finish_txn(e);
    exp_mem[8'h60] = 8'h5C;
    repeat (200) @(negedge clk);
    chk(busy == 1'b0, "R10", "no second transaction", int'(busy), 0);
    chk(n_start - s0 == 1, "R10", "one START only", n_start - s0, 1);
    chk(n_valid == v0, "R10", "no read from ignored start", n_valid - v0, 0);
    chk(mem[8'h60] == exp_mem[8'h60], "R10", "first command completed", int'(mem[8'h60]), int'(exp_mem[8'h60]));
    chk(exp_q.size() == 0, "R7", "all expected bytes seen", exp_q.size(), 0);

    summary_and_end();
  end

endmodule